// File: doc/BRIEF.md
# I2C Slave Register Control Port

This block is an I2C target that gives a bus master access to a small register file through a one-byte pointer. It watches the open-drain clock and data lines after synchronizing them to the system clock. It recognises START, repeated START and STOP, and compares the seven address bits with a fixed six-bit prefix followed by a strap-selected bit. It signals acknowledge, and sends read data, by enabling a pull-down on the data line. It never holds the clock line low.

The first byte after a write address is loaded into the pointer. Its top bit is an auto-increment flag and its low bits pick a register. The bytes that follow are stored into the registers. A read is normally done by writing the pointer, then issuing a repeated START with the read address. The pointer also survives STOP, so a later read-only transaction continues from the last pointer value. When the flag is set, bursts in either direction step through successive registers and wrap at the top of the file. When the flag is clear, one transaction reaches a single register.

Top module: `i2c_regport`

## Requirements
- R1: A byte after START is accepted when its upper seven bits equal 0010000 with the strap value in place of the last zero (strap 1 gives write address 0x22 and read address 0x23), and its lowest bit selects write (0) or read (1). The block acknowledges an accepted address by pulling SDA low during the ninth clock.
- R2: After an address that does not match, the block never pulls SDA low until the next START, and stores nothing.
- R3: In a write transaction the byte after the address is acknowledged and becomes the pointer. Bit 7 is the increment flag, and the low four bits are the register index (16 registers, so index bits 6 to 4 are ignored).
- R4: Each later byte of a write transaction is acknowledged during its ninth clock, and the first of them is stored into the register that the pointer selects.
- R5: With the increment flag at 1, every data byte of a write is stored and the pointer then advances by one, wrapping from register 15 to register 0.
- R6: With the increment flag at 0, only the first data byte of a write transaction is stored. Later bytes are acknowledged but leave every register unchanged.
- R7: A read address returns the register selected by the current pointer, MSB first, starting right after the address acknowledge clock. The pointer keeps its value across STOP and START.
- R8: During a read the master's acknowledge level is ignored, and bytes keep coming until STOP. With the flag at 1 the pointer advances after each byte. With the flag at 0 the same register is sent again.
- R9: The SDA pull-down changes only while SCL is low.
- R10: After reset the SDA pull-down is off and the pointer is index 0 with the flag at 0. Register contents are not cleared by reset.
- R11: A START or a STOP in the middle of a byte abandons that byte, so a partly received data byte is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_strap_i | input | 1 | Strap that sets the lowest device address bit |
| sda_pd_o | output | 1 | Enables the pull-down on the data line |

## Verification
A corrupted pointer shows up at the pins in the next read: the wrong register's bits appear on SDA at the first falling clock after the read address acknowledge, within one byte time. A wrong increment or wrap decision appears as a byte that repeats or skips during a read burst. It can also show as an overwritten neighbour that a later read exposes. A framing error in the bit counter shifts the acknowledge pulse out of the ninth clock, and a wrong state after a mismatch or an aborted byte shows as an unexpected pull-down or a stored value. The bench follows every write with reads of the affected registers, so each of these faults surfaces within one or two transactions.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_MAP,
    PH_WDATA,
    PH_RDATA,
    PH_SKIP
  } phase_t;

  localparam logic [5:0] DEFAULT_PREFIX = 6'b001000;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_regport_sync.sv
module i2c_regport_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;
  logic              scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = ~scl_q & scl_s;
  assign scl_fall  = scl_q & ~scl_s;
  assign bus_start = scl_q & scl_s & sda_q & ~sda_s;
  assign bus_stop  = scl_q & scl_s & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_regport_regs.sv
module i2c_regport_regs #(
  parameter int DEPTH  = 16,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    rdata <= mem[ridx];
  end
endmodule

// File: rtl/i2c_regport_ctrl.sv
module i2c_regport_ctrl
  import i2c_regport_pkg::*;
#(
  parameter int         IDX_W  = 4,
  parameter logic [5:0] PREFIX = DEFAULT_PREFIX
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              sda_s,
  input  logic              strap_i,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_pd,
  output logic              we,
  output logic [IDX_W-1:0]  widx,
  output logic [BYTE_W-1:0] wdata,
  output logic [IDX_W-1:0]  ptr_idx
);
  phase_t            phase;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] txreg;
  logic              rw;
  logic              ptr_incr;
  logic              wr_first;
  logic [2:0]        tx_sel;
  logic              active;
  logic              addr_hit;
  logic              read_load;

  always_comb begin
    tx_sel    = 3'(4'd7 - bitcnt);
    active    = (phase != PH_IDLE) && (phase != PH_SKIP);
    addr_hit  = (shreg[7:1] == {PREFIX, strap_i});
    read_load = (phase == PH_RDATA) || ((phase == PH_ADDR) && rw);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      txreg    <= '0;
      rw       <= 1'b0;
      ptr_incr <= 1'b0;
      ptr_idx  <= '0;
      wr_first <= 1'b0;
      sda_pd   <= 1'b0;
      we       <= 1'b0;
      widx     <= '0;
      wdata    <= '0;
    end else begin
      we <= 1'b0;
      if (bus_start) begin
        phase  <= PH_ADDR;
        bitcnt <= '0;
        sda_pd <= 1'b0;
      end else if (bus_stop) begin
        phase  <= PH_IDLE;
        bitcnt <= '0;
        sda_pd <= 1'b0;
      end else if (active) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) shreg <= {shreg[BYTE_W-2:0], sda_s};
          if (bitcnt != 4'd9) bitcnt <= 4'(bitcnt + 4'd1);
        end else if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            case (phase)
              PH_ADDR: begin
                if (addr_hit) begin
                  sda_pd <= 1'b1;
                  rw     <= shreg[0];
                end else begin
                  phase <= PH_SKIP;
                end
              end
              PH_MAP: begin
                ptr_incr <= shreg[7];
                ptr_idx  <= shreg[IDX_W-1:0];
                wr_first <= 1'b1;
                sda_pd   <= 1'b1;
              end
              PH_WDATA: begin
                sda_pd   <= 1'b1;
                wr_first <= 1'b0;
                if (wr_first || ptr_incr) begin
                  we    <= 1'b1;
                  widx  <= ptr_idx;
                  wdata <= shreg;
                  if (ptr_incr) ptr_idx <= IDX_W'(ptr_idx + 1'b1);
                end
              end
              PH_RDATA: begin
                sda_pd <= 1'b0;
                if (ptr_incr) ptr_idx <= IDX_W'(ptr_idx + 1'b1);
              end
              default: ;
            endcase
          end else if (bitcnt == 4'd9) begin
            bitcnt <= '0;
            sda_pd <= 1'b0;
            if (phase == PH_ADDR) phase <= rw ? PH_RDATA : PH_MAP;
            else if (phase == PH_MAP) phase <= PH_WDATA;
            if (read_load) begin
              txreg  <= rd_data;
              sda_pd <= ~rd_data[7];
            end
          end else if ((phase == PH_RDATA) && (bitcnt != 4'd0)) begin
            sda_pd <= ~txreg[tx_sel];
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2c_regport_pkg::*;
#(
  parameter int         REG_COUNT   = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] DEV_PREFIX  = DEFAULT_PREFIX
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic addr_strap_i,
  output logic sda_pd_o
);
  localparam int IDX_W = $clog2(REG_COUNT);

  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              bus_start;
  logic              bus_stop;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;
  logic [IDX_W-1:0]  rd_idx;
  logic [BYTE_W-1:0] rd_data;

  i2c_regport_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop)
  );

  i2c_regport_ctrl #(.IDX_W(IDX_W), .PREFIX(DEV_PREFIX)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .sda_s     (sda_s),
    .strap_i   (addr_strap_i),
    .rd_data   (rd_data),
    .sda_pd    (sda_pd_o),
    .we        (wr_en),
    .widx      (wr_idx),
    .wdata     (wr_data),
    .ptr_idx   (rd_idx)
  );

  i2c_regport_regs #(.DEPTH(REG_COUNT), .IDX_W(IDX_W), .DATA_W(BYTE_W)) regs_i (
    .clk   (clk),
    .we    (wr_en),
    .widx  (wr_idx),
    .wdata (wr_data),
    .ridx  (rd_idx),
    .rdata (rd_data)
  );
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic sda_pd_o,
  input logic reg_we
);
  AST_PD_OFF_AFTER_RESET: assert property (@(posedge clk) $past(rst) |-> !sda_pd_o); // R10
  AST_PD_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst) !$stable(sda_pd_o) |-> !scl_i); // R9
  AST_STORE_WITH_ACK: assert property (@(posedge clk) disable iff (rst) reg_we |-> sda_pd_o); // R4
  AST_ONE_STORE_PER_BYTE: assert property (@(posedge clk) disable iff (rst) reg_we |=> !reg_we); // R6
endmodule

bind i2c_regport i2c_regport_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .scl_i    (scl_i),
  .sda_pd_o (sda_pd_o),
  .reg_we   (wr_en)
);

// File: tb/i2c_regport_tb_top.sv
module i2c_regport_tb_top;
  localparam int Q = 8;
  localparam logic [7:0] WADDR = 8'h22;
  localparam logic [7:0] RADDR = 8'h23;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pd_o;
  logic sda_bus;

  int n_checks = 0;
  int n_fail = 0;
  int r9_viol = 0;
  int r2_viol = 0;
  bit r2_watch = 1'b0;
  logic pd_prev = 1'b0;

  logic [7:0] mreg [16];
  int midx = 0;
  bit mincr = 1'b0;
  bit mfirst = 1'b0;

  always #2 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pd_o;

  i2c_regport dut_i (
    .clk          (clk),
    .rst          (rst),
    .scl_i        (scl_m),
    .sda_i        (sda_bus),
    .addr_strap_i (1'b1),
    .sda_pd_o     (sda_pd_o)
  );

  always @(negedge clk) begin
    if (!rst && (sda_pd_o !== pd_prev) && scl_m) r9_viol++;
    if (r2_watch && sda_pd_o) r2_viol++;
    pd_prev <= sda_pd_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1;
    qwait();
    scl_m = 1'b1;
    qwait();
    sda_m = 1'b0;
    qwait();
    scl_m = 1'b0;
  endtask

  task automatic clk_bit(input logic b, output logic smp);
    qwait();
    sda_m = b;
    qwait();
    scl_m = 1'b1;
    qwait();
    smp = sda_bus;
    qwait();
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    logic dummy;
    bit done = 1'b0;
    for (int k = 0; k < 20 && !done; k++) begin
      qwait();
      if (sda_pd_o) begin
        clk_bit(1'b1, dummy);
      end else begin
        sda_m = 1'b0;
        qwait();
        scl_m = 1'b1;
        qwait();
        sda_m = 1'b1;
        qwait();
        done = 1'b1;
      end
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    logic smp;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], smp);
    clk_bit(1'b1, smp);
    acked = !smp;
  endtask

  task automatic recv_byte(input logic ackbit, output logic [7:0] b);
    logic smp;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, smp);
      b[i] = smp;
    end
    clk_bit(ackbit, smp);
  endtask

  function automatic int next_idx(input int i);
    return (i + 1) % 16;
  endfunction

  task automatic model_map(input logic [7:0] map);
    mincr = map[7];
    midx = int'(map[3:0]);
    mfirst = 1'b1;
  endtask

  task automatic model_store(input logic [7:0] d);
    if (mfirst || mincr) begin
      mreg[midx] = d;
      if (mincr) midx = next_idx(midx);
    end
    mfirst = 1'b0;
  endtask

  task automatic addr_map(input logic [7:0] map, input string req);
    bit ack;
    bus_start();
    send_byte(WADDR, ack);
    check(ack, "R1", int'(ack), 1);
    send_byte(map, ack);
    check(ack, req, int'(ack), 1);
    model_map(map);
  endtask

  task automatic do_write(input logic [7:0] map, input int n, input string req);
    bit ack;
    logic [7:0] d;
    addr_map(map, "R3");
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send_byte(d, ack);
      check(ack, "R4", int'(ack), 1);
      model_store(d);
    end
    bus_stop();
  endtask

  task automatic read_bytes(input int n, input string req);
    bit ack;
    logic [7:0] got;
    logic [7:0] exp;
    send_byte(RADDR, ack);
    check(ack, "R1", int'(ack), 1);
    for (int i = 0; i < n; i++) begin
      exp = mreg[midx];
      recv_byte(1'($urandom), got);
      check(got === exp, req, int'(got), int'(exp));
      if (mincr) midx = next_idx(midx);
    end
    bus_stop();
  endtask

  task automatic do_read_map(input logic [7:0] map, input int n, input string req);
    addr_map(map, "R3");
    bus_start();
    read_bytes(n, req);
  endtask

  task automatic do_read_plain(input int n, input string req);
    bus_start();
    read_bytes(n, req);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    midx = 0;
    mincr = 1'b0;
    mfirst = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    bit ack;
    logic smp;
    int seed;
    logic [7:0] map;
    int n;
    seed = 7;
    void'($urandom(seed));
    do_reset();
    check(sda_pd_o == 1'b0, "R10", int'(sda_pd_o), 0);

    // Fill every register with an incrementing burst, then read it all back
    do_write(8'h80, 16, "R5");
    do_read_map(8'h80, 16, "R8");

    // Wrap from 15 to 0
    do_write(8'h8E, 4, "R5");
    do_read_map(8'h8E, 4, "R5");

    // Flag clear: only the first byte lands
    do_write(8'h05, 3, "R6");
    do_read_map(8'h85, 2, "R6");

    // Pointer retained across STOP (R7)
    do_write(8'h89, 0, "R7");
    do_read_plain(3, "R7");

    // Flag clear on read repeats the same register
    do_read_map(8'h03, 3, "R8");

    // Upper index bits ignored: 0x93 selects register 3
    do_write(8'h93, 1, "R3");
    do_read_map(8'h03, 1, "R3");

    // Address mismatch, write and read direction (R2)
    r2_watch = 1'b1;
    bus_start();
    send_byte(8'h20, ack);
    check(!ack, "R2", int'(ack), 0);
    send_byte(8'h81, ack);
    send_byte(8'h55, ack);
    bus_stop();
    bus_start();
    send_byte(8'h21, ack);
    check(!ack, "R2", int'(ack), 0);
    send_byte(8'hFF, ack);
    bus_stop();
    r2_watch = 1'b0;
    check(r2_viol == 0, "R2", r2_viol, 0);
    do_read_map(8'h81, 1, "R2");

    // STOP in the middle of a data byte (R11)
    addr_map(8'h87, "R3");
    for (int i = 0; i < 4; i++) clk_bit(1'b0, smp);
    bus_stop();
    do_read_map(8'h07, 1, "R11");

    // Repeated START in the middle of a data byte, then read (R11)
    addr_map(8'h08, "R3");
    for (int i = 0; i < 3; i++) clk_bit(1'b1, smp);
    bus_start();
    read_bytes(2, "R11");

    // Reset puts the pointer at 0 with the flag clear, contents kept (R10)
    do_reset();
    do_read_plain(2, "R10");

    // Random write bursts checked by readback
    for (int t = 0; t < 12; t++) begin
      map = 8'($urandom);
      n = 1 + int'($urandom % 4);
      do_write(map, n, "R4");
      do_read_map({1'b1, map[6:0]}, n + 1, "R5");
    end

    check(r9_viol == 0, "R9", r9_viol, 0);
    finish_run();
  end
endmodule